// File: doc/BRIEF.md
# Program Image Checksum Engine

This block produces the 16-bit verification checksum of an image of 12-bit program words. Words reach it in one of two ways: a host pushes them over a valid/ready stream that marks the final word, or the engine itself walks an inclusive address range. In the second case it issues one read per cycle to a memory with a single cycle of read latency. Each word adds either its full value or the XOR of its three 4-bit nibbles. The XOR form reproduces what a protected device returns when it is read.

When the run starts, three fixed terms are folded into the accumulator. The first is the configuration word ANDed with a selectable mask. The second is an optional legacy constant of 0x0FF0. The third is an optional ID term, built by packing four ID nibbles into 16 bits with ID 0 in the top nibble.

All mode, mask, range and ID inputs are captured on the start strobe. Changes made while a run is in progress therefore have no effect. Carries out of bit 15 are dropped. The final value appears on a registered output together with a one-cycle valid pulse.

Top module: `imgsum_engine`

## Requirements
- R1: After reset, result is 0x0000, and result_valid, in_ready and rd_en are all 0.
- R2: In stream mode (use_sweep=0 at start), each word accepted while in_valid and in_ready are both 1 adds to the sum. When the accepted word has in_last=1, result holds the 16-bit total and result_valid is 1 for exactly one cycle. That cycle is the one following the clock edge of the handshake.
- R3: With xor_mode=1, a word contributes zero-extended (w[11:8] ^ w[7:4] ^ w[3:0]) instead of w. Words 0x123 and 0x456 with every other term zero give 0x0007.
- R4: The configuration term equals cfg_word & cfg_mask, zero-extended to 16 bits. Any mask value is allowed, for example 0x00F, 0x00B or 0xFFF.
- R5: With const_en=1, the constant 0x0FF0 is added.
- R6: With id_en=1, a packed ID value is added. ID k is id_nib[4k+3:4k], and it lands at result bits [15-4k:12-4k], so ID 0 is the most significant nibble. id_nib=0x4321 adds 0x1234.
- R7: In sweep mode (use_sweep=1 at start), rd_en is 1 for exactly range_hi-range_lo+1 consecutive cycles, starting the cycle after start. rd_addr climbs by one from range_lo to range_hi. rd_data is taken the cycle after each read, and result_valid is seen in the cycle after the data for range_hi arrives. range_lo <= range_hi is required.
- R8: Mode, mask, configuration word, ID and range inputs are sampled only by a start strobe that arrives while the engine is idle. A start or input change during a run has no effect on that run.
- R9: Carries beyond bit 15 are discarded. A swept 512-word image of 0xFFF words gives 0x0DFF in two cases: with cfg_word=0xFFF and mask 0xFFF, and with mask 0x00F plus the 0x0FF0 constant.
- R10: in_ready is 0 outside a stream run. Words offered while the engine is idle are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe; clears the accumulator and captures the configuration while idle |
| use_sweep | input | 1 | 1 = walk the address range, 0 = take the word stream |
| xor_mode | input | 1 | 1 = accumulate the nibble XOR of each word |
| const_en | input | 1 | Add the legacy constant |
| id_en | input | 1 | Add the packed ID term |
| cfg_word | input | 12 | Configuration word |
| cfg_mask | input | 12 | Mask applied to the configuration word |
| id_nib | input | 16 | Four ID nibbles, ID k at bits [4k+3:4k] |
| range_lo | input | 12 | First address of a sweep |
| range_hi | input | 12 | Last address of a sweep (inclusive) |
| in_valid | input | 1 | Stream word valid |
| in_ready | output | 1 | Engine accepts stream words |
| in_word | input | 12 | Stream word |
| in_last | input | 1 | Marks the final stream word |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | 12 | Memory read address |
| rd_data | input | 12 | Read data, one cycle after rd_en |
| result | output | 16 | Checksum |
| result_valid | output | 1 | One-cycle pulse when result is new |

## Verification
The hardest case to reach is a run whose sum wraps many times through bit 15 and still has to land on a known value. The bench drives it with a full 512-word sweep of an all-ones image under both configuration-term recipes, and expects 0x0DFF in each. Capture on start is tested by flipping xor_mode and pulsing start in the middle of a stream. In sweep runs, the number of read cycles and the exact cycle of the result are counted against the range length.

// File: rtl/imgsum_pkg.sv
package imgsum_pkg;
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_STREAM = 2'd1,
      PH_SWEEP  = 2'd2
   } phase_t;

   localparam int unsigned NIB_W = 4;
endpackage

// File: rtl/imgsum_term.sv
module imgsum_term #(
   parameter int unsigned WORD_W      = 12,
   parameter int unsigned SUM_W       = 16,
   parameter bit          XOR_SUPPORT = 1'b1
) (
   input  logic [WORD_W-1:0] word,
   input  logic              xor_mode,
   output logic [SUM_W-1:0]  term
);
   import imgsum_pkg::*;
   localparam int unsigned NIBS = WORD_W / NIB_W;

   if (WORD_W % NIB_W != 0) begin : g_bad_width
      $error("imgsum_term: WORD_W must be a multiple of 4");
   end
   if (SUM_W <= WORD_W) begin : g_bad_sum
      $error("imgsum_term: SUM_W must exceed WORD_W");
   end

   logic [NIB_W-1:0] fold [NIBS+1];
   assign fold[0] = '0;
   for (genvar i = 0; i < NIBS; i++) begin : g_fold
      assign fold[i+1] = fold[i] ^ word[i*NIB_W +: NIB_W];
   end

   logic [SUM_W-1:0] full_ext, fold_ext;
   assign full_ext = {{(SUM_W-WORD_W){1'b0}}, word};
   assign fold_ext = {{(SUM_W-NIB_W){1'b0}}, fold[NIBS]};

   if (XOR_SUPPORT) begin : g_with_xor
      assign term = xor_mode ? fold_ext : full_ext;
   end else begin : g_plain_only
      logic unused_sel;
      assign unused_sel = xor_mode ^ (^fold_ext);
      assign term = full_ext;
   end
endmodule

// File: rtl/imgsum_base.sv
module imgsum_base #(
   parameter int unsigned   WORD_W     = 12,
   parameter int unsigned   SUM_W      = 16,
   parameter int unsigned   N_ID       = 4,
   parameter logic [SUM_W-1:0] CONST_TERM = 16'h0FF0
) (
   input  logic [WORD_W-1:0] cfg_word,
   input  logic [WORD_W-1:0] cfg_mask,
   input  logic              const_en,
   input  logic              id_en,
   input  logic [N_ID*4-1:0] id_nib,
   output logic [SUM_W-1:0]  base
);
   localparam int unsigned ID_BITS = N_ID * 4;

   if (ID_BITS > SUM_W) begin : g_bad_id
      $error("imgsum_base: ID nibbles do not fit the sum width");
   end

   logic [SUM_W-1:0] packed_id;
   for (genvar k = 0; k < N_ID; k++) begin : g_pack
      assign packed_id[SUM_W-1-4*k -: 4] = id_nib[4*k +: 4];
   end
   if (ID_BITS < SUM_W) begin : g_pad
      assign packed_id[SUM_W-ID_BITS-1:0] = '0;
   end

   logic [SUM_W-1:0] cfg_term;
   assign cfg_term = {{(SUM_W-WORD_W){1'b0}}, cfg_word & cfg_mask};

   assign base = cfg_term
               + (const_en ? CONST_TERM : '0)
               + (id_en ? packed_id : '0);
endmodule

// File: rtl/imgsum_sweep.sv
module imgsum_sweep #(
   parameter int unsigned ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic [ADDR_W-1:0] lo,
   input  logic [ADDR_W-1:0] hi,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              data_vld,
   output logic              data_last
);
   logic              active;
   logic [ADDR_W-1:0] addr_q, hi_q;
   logic              at_end;

   assign at_end  = (addr_q == hi_q);
   assign rd_en   = active;
   assign rd_addr = addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         addr_q    <= '0;
         hi_q      <= '0;
         data_vld  <= 1'b0;
         data_last <= 1'b0;
      end else begin
         data_vld  <= active;
         data_last <= active && at_end;
         if (launch) begin
            active <= 1'b1;
            addr_q <= lo;
            hi_q   <= hi;
         end else if (active) begin
            if (at_end) active <= 1'b0;
            else        addr_q <= addr_q + 1'b1;
         end
      end
   end

   // R7: consecutive reads step the address by one
   assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + 1'b1));
endmodule

// File: rtl/imgsum_engine.sv
module imgsum_engine #(
   parameter int unsigned      WORD_W      = 12,
   parameter int unsigned      SUM_W       = 16,
   parameter int unsigned      ADDR_W      = 12,
   parameter int unsigned      N_ID        = 4,
   parameter logic [SUM_W-1:0] CONST_TERM  = 16'h0FF0,
   parameter bit               XOR_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              use_sweep,
   input  logic              xor_mode,
   input  logic              const_en,
   input  logic              id_en,
   input  logic [WORD_W-1:0] cfg_word,
   input  logic [WORD_W-1:0] cfg_mask,
   input  logic [N_ID*4-1:0] id_nib,
   input  logic [ADDR_W-1:0] range_lo,
   input  logic [ADDR_W-1:0] range_hi,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_word,
   input  logic              in_last,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [WORD_W-1:0] rd_data,
   output logic [SUM_W-1:0]  result,
   output logic              result_valid
);
   import imgsum_pkg::*;

   phase_t            phase;
   logic              xor_q;
   logic [SUM_W-1:0]  acc;
   logic [SUM_W-1:0]  base, term_val, next_sum;
   logic [WORD_W-1:0] word_sel;
   logic              start_ok, launch, data_vld, data_last;
   logic              take, take_last;

   assign start_ok = start && (phase == PH_IDLE);
   assign launch   = start_ok && use_sweep;
   assign in_ready = (phase == PH_STREAM);

   imgsum_base #(.WORD_W(WORD_W), .SUM_W(SUM_W), .N_ID(N_ID), .CONST_TERM(CONST_TERM)) u_base (
      .cfg_word (cfg_word),
      .cfg_mask (cfg_mask),
      .const_en (const_en),
      .id_en    (id_en),
      .id_nib   (id_nib),
      .base     (base)
   );

   imgsum_sweep #(.ADDR_W(ADDR_W)) u_sweep (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (launch),
      .lo        (range_lo),
      .hi        (range_hi),
      .rd_en     (rd_en),
      .rd_addr   (rd_addr),
      .data_vld  (data_vld),
      .data_last (data_last)
   );

   assign word_sel = (phase == PH_SWEEP) ? rd_data : in_word;

   imgsum_term #(.WORD_W(WORD_W), .SUM_W(SUM_W), .XOR_SUPPORT(XOR_SUPPORT)) u_term (
      .word     (word_sel),
      .xor_mode (xor_q),
      .term     (term_val)
   );

   assign next_sum = acc + term_val;

   always_comb begin
      take      = 1'b0;
      take_last = 1'b0;
      if (phase == PH_STREAM) begin
         take      = in_valid;
         take_last = in_valid && in_last;
      end else if (phase == PH_SWEEP) begin
         take      = data_vld;
         take_last = data_vld && data_last;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase        <= PH_IDLE;
         xor_q        <= 1'b0;
         acc          <= '0;
         result       <= '0;
         result_valid <= 1'b0;
      end else begin
         result_valid <= 1'b0;
         if (start_ok) begin
            xor_q <= xor_mode;
            acc   <= base;
            phase <= use_sweep ? PH_SWEEP : PH_STREAM;
         end else if (take_last) begin
            result       <= next_sum;
            result_valid <= 1'b1;
            acc          <= next_sum;
            phase        <= PH_IDLE;
         end else if (take) begin
            acc <= next_sum;
         end
      end
   end

   // R2: the final handshake produces a result in the next cycle
   assert_last_gives_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_last) |=> result_valid);
   // R2: the valid flag is a single-cycle pulse
   assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> !result_valid);
   // R8: the captured mode does not change during a run
   assert_mode_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase != PH_IDLE) && ($past(phase) != PH_IDLE)) |-> $stable(xor_q));
   // R10: stream acceptance stops after the last word
   assert_ready_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_last) |=> !in_ready);
endmodule

// File: tb/imgsum_engine_bench.sv
module imgsum_engine_bench;
   logic clk = 1'b0, rst_n = 1'b0;
   always #2 clk = ~clk;

   logic start = 0, use_sweep = 0, xor_mode = 0, const_en = 0, id_en = 0;
   logic [11:0] cfg_word = 0, cfg_mask = 0, range_lo = 0, range_hi = 0;
   logic [15:0] id_nib = 0;
   logic in_valid = 0, in_last = 0;
   logic [11:0] in_word = 0;
   logic in_ready, rd_en, result_valid;
   logic [11:0] rd_addr, rd_data;
   logic [15:0] result;
   bit blank = 0;

   int checks = 0, errors = 0, cyc = 0;

   imgsum_engine u_imgsum_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .use_sweep(use_sweep),
      .xor_mode(xor_mode), .const_en(const_en), .id_en(id_en),
      .cfg_word(cfg_word), .cfg_mask(cfg_mask), .id_nib(id_nib),
      .range_lo(range_lo), .range_hi(range_hi), .in_valid(in_valid),
      .in_ready(in_ready), .in_word(in_word), .in_last(in_last),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .result(result), .result_valid(result_valid));

   function automatic logic [11:0] mem_fn(input int a);
      int v;
      v = blank ? 12'hFFF : ((a * 37) ^ (a >> 3)) + 12'h5A1;
      return v[11:0];
   endfunction

   always @(posedge clk) rd_data <= rd_en ? mem_fn(int'(rd_addr)) : 12'h000;

   function automatic logic [15:0] contrib(input logic [11:0] w, input bit x);
      return x ? {12'h000, w[11:8] ^ w[7:4] ^ w[3:0]} : {4'h0, w};
   endfunction

   function automatic logic [15:0] base_of(input logic [11:0] cw, input logic [11:0] m,
                                           input bit ce, input bit ie, input logic [15:0] ids);
      logic [15:0] pk;
      for (int k = 0; k < 4; k++) pk[15-4*k -: 4] = ids[4*k +: 4];
      return {4'h0, cw & m} + (ce ? 16'h0FF0 : 16'h0) + (ie ? pk : 16'h0);
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic setup(input bit sw, input bit x, input bit ce, input bit ie,
                        input logic [11:0] cw, input logic [11:0] m, input logic [15:0] ids);
      use_sweep = sw; xor_mode = x; const_en = ce; id_en = ie;
      cfg_word = cw; cfg_mask = m; id_nib = ids;
   endtask

   // stream n words; disturb=1 flips mode inputs and pulses start mid-run (R8)
   task automatic stream(input string tag, input int n, input int seed, input bit x,
                         input bit ce, input bit ie, input logic [11:0] cw,
                         input logic [11:0] m, input logic [15:0] ids, input bit disturb);
      logic [15:0] exp;
      logic [11:0] w;
      exp = base_of(cw, m, ce, ie, ids);
      setup(0, x, ce, ie, cw, m, ids);
      start = 1;
      @(negedge clk);
      start = 0;
      for (int i = 0; i < n; i++) begin
         w = 12'((seed * 131 + i * 977 + i * i * 13) ^ (seed << 4));
         exp += contrib(w, x);
         in_valid = 1; in_word = w; in_last = (i == n-1);
         if (disturb && i == 1) begin
            xor_mode = ~x; start = 1; cfg_mask = 12'hFFF; cfg_word = 12'h777;
         end
         if (i == 0) check({tag, " R10 in_ready during stream"}, in_ready, 1);
         @(negedge clk);
         start = 0; xor_mode = x;
      end
      in_valid = 0; in_last = 0;
      check({tag, " R2 valid pulse"}, result_valid, 1);
      check({tag, " R2 sum"}, result, exp);
      @(negedge clk);
      check({tag, " R2 valid single cycle"}, result_valid, 0);
   endtask

   task automatic sweep(input string tag, input int lo, input int hi, input bit x,
                        input bit ce, input bit ie, input logic [11:0] cw,
                        input logic [11:0] m, input logic [15:0] ids,
                        input bit use_exp, input logic [15:0] given);
      logic [15:0] exp;
      int reads, addr_bad, seen;
      exp = base_of(cw, m, ce, ie, ids);
      for (int a = lo; a <= hi; a++) exp += contrib(mem_fn(a), x);
      if (use_exp) exp = given;
      setup(1, x, ce, ie, cw, m, ids);
      range_lo = 12'(lo); range_hi = 12'(hi);
      start = 1;
      @(negedge clk);
      start = 0;
      reads = 0; addr_bad = 0; seen = 0;
      for (int t = 1; t < 5000 && seen == 0; t++) begin
         if (rd_en) begin
            if (int'(rd_addr) != lo + reads) addr_bad++;
            reads++;
         end
         if (result_valid) begin
            seen = t;
            check({tag, " R9 sweep sum"}, result, exp);
         end else @(negedge clk);
      end
      check({tag, " R7 read count"}, reads, hi - lo + 1);
      check({tag, " R7 address order"}, addr_bad, 0);
      check({tag, " R7 result cycle"}, seen, hi - lo + 3);
      @(negedge clk);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 result", result, 0);
      check("R1 result_valid", result_valid, 0);
      check("R1 in_ready", in_ready, 0);
      check("R1 rd_en", rd_en, 0);
      rst_n = 1;
      @(negedge clk);

      // R3 example: 0x123 and 0x456 in XOR mode give 0x0007
      setup(0, 1, 0, 0, 12'h000, 12'h000, 16'h0);
      start = 1; @(negedge clk); start = 0;
      in_valid = 1; in_word = 12'h123; in_last = 0; @(negedge clk);
      in_word = 12'h456; in_last = 1; @(negedge clk);
      in_valid = 0; in_last = 0;
      check("R3 xor example", result, 16'h0007);
      @(negedge clk);

      // R10: words offered while idle are ignored
      in_valid = 1; in_word = 12'h7FF; in_last = 1;
      for (int i = 0; i < 3; i++) begin
         check("R10 in_ready idle", in_ready, 0);
         @(negedge clk);
         check("R10 no result from idle words", result_valid, 0);
      end
      in_valid = 0; in_last = 0;
      stream("R10 after idle offer", 1, 3, 0, 0, 0, 12'h000, 12'h000, 16'h0, 0);

      // R2 R3 R5 R6: every mode combination
      for (int c = 0; c < 8; c++)
         stream("R2/R3/R5/R6 combo", 5 + c * 7, c + 1, c[0], c[1], c[2],
                12'hA5C, 12'h00F, 16'h4321, 0);
      stream("R6 id pack", 1, 9, 0, 0, 1, 12'h000, 12'h000, 16'h4321, 0);

      // R4: mask sweep
      for (int k = 0; k < 3; k++)
         stream("R4 mask", 4, 20 + k, 0, 0, 0, 12'hA5C,
                (k == 0) ? 12'h00F : (k == 1) ? 12'h00B : 12'hFFF, 16'h0, 0);

      // R8: mid-run start and mode change are ignored
      stream("R8 capture at start", 6, 40, 0, 1, 0, 12'h135, 12'h00B, 16'h0, 1);
      stream("R8 capture xor", 6, 41, 1, 0, 1, 12'h135, 12'h00F, 16'h9ABC, 1);

      // R7: address ranges, including single word
      sweep("R7 single", 12'h040, 12'h040, 0, 0, 0, 12'h0, 12'h0, 16'h0, 0, 0);
      sweep("R7 protected range", 0, 12'h03F, 1, 0, 1, 12'hFF3, 12'h00F, 16'h4321, 0, 0);
      sweep("R7 mid range", 12'h1F0, 12'h213, 0, 1, 0, 12'h00F, 12'hFFF, 16'h0, 0, 0);

      // R9: blank image with wrap-around
      blank = 1;
      sweep("R9 blank full mask", 0, 12'h1FF, 0, 0, 0, 12'hFFF, 12'hFFF, 16'h0, 1, 16'h0DFF);
      sweep("R9 blank const", 0, 12'h1FF, 0, 1, 0, 12'hFFF, 12'h00F, 16'h0, 1, 16'h0DFF);
      blank = 0;

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule